// File: doc/BRIEF.md
# AXI4 to Wishbone Bridge

The bridge is an AXI4 slave that drives a classic Wishbone master port. Every AXI beat, read or write, becomes one single-word Wishbone cycle on a 32-bit data bus with a 30-bit word address. Only one burst is in flight at a time. A round-robin arbiter chooses between a pending write address and a pending read address. The chosen burst then runs from start to finish before the next one is accepted.

A write burst moves through the states IDLE, WDATA, WBUS and WRESP:
- IDLE goes to WDATA when the write is granted.
- WDATA goes to WBUS when a W beat is accepted.
- WBUS goes back to WDATA on a Wishbone ACK of a beat that is not the last one. It goes to WRESP on the ACK of the last beat.
- WRESP goes to IDLE when the B response is taken.

A read burst moves through the states IDLE, RBUS and RDATA:
- IDLE goes to RBUS when the read is granted.
- RBUS goes to RDATA on a Wishbone ACK.
- RDATA goes back to RBUS when an R beat that is not the last is taken. It goes to IDLE when the last R beat is taken.

A burst expander computes the byte address of each beat from the start address, the beat size, the length and the burst kind. The burst kind codes are 0 = FIXED, 1 = INCR, 2 = WRAP; code 3 is treated as INCR.

Top module: `axi_wb_bridge`

## Requirements
- R1: After reset the block is idle: `wb_cyc`, `wb_stb`, `b_valid` and `r_valid` are low. `aw_ready` and `ar_ready` stay low while no address valid is presented.
- R2: The first beat of a burst drives `wb_adr` equal to the AXI byte address shifted right by two bits.
- R3: In an INCR burst (code 1), each following beat adds 2^size bytes to the previous byte address.
- R4: In a FIXED burst (code 0), every beat uses the start address.
- R5: In a WRAP burst (code 2), the window is W = (len+1)·2^size bytes. Beat i uses base + ((start mod W) + i·2^size) mod W, where base is the start address rounded down to a multiple of W.
- R6: A write beat drives `wb_we`=1, `wb_dat_w` = W data and `wb_sel` = W strobe. `wb_cyc` and `wb_stb` stay high, with address, data, select and `wb_we` unchanged, until `wb_ack`.
- R7: Each write burst gives exactly one B response. It appears only after the Wishbone ACK of its final beat. `b_id` equals the AW id and `b_resp` is 00 (OKAY).
- R8: A read beat drives `wb_we`=0 and `wb_sel` all ones. The R beat carries the `wb_dat_r` value captured at that ACK, the AR id, and `r_resp` = 00.
- R9: A read burst of len+1 beats returns len+1 R beats. `r_last` is high on the final beat only.
- R10: While `b_valid` or `r_valid` waits for its ready, the valid and its payload stay unchanged.
- R11: From the acceptance of an address until the B handshake or the final R handshake, `aw_ready` and `ar_ready` stay low.
- R12: When both address channels are valid in IDLE, the grant alternates, and the write wins first after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address accepted |
| aw_addr | input | 32 | Write start byte address |
| aw_id | input | 8 | Write transaction id |
| aw_len | input | 8 | Write beats minus one |
| aw_size | input | 3 | log2 of bytes per write beat |
| aw_burst | input | 2 | Write burst kind |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data accepted |
| w_data | input | 32 | Write data |
| w_strb | input | 4 | Write byte strobes |
| w_last | input | 1 | Final write beat marker |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response taken |
| b_id | output | 8 | Write response id |
| b_resp | output | 2 | Write response code |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address accepted |
| ar_addr | input | 32 | Read start byte address |
| ar_id | input | 8 | Read transaction id |
| ar_len | input | 8 | Read beats minus one |
| ar_size | input | 3 | log2 of bytes per read beat |
| ar_burst | input | 2 | Read burst kind |
| r_valid | output | 1 | Read data valid |
| r_ready | input | 1 | Read data taken |
| r_data | output | 32 | Read data |
| r_id | output | 8 | Read data id |
| r_resp | output | 2 | Read response code |
| r_last | output | 1 | Final read beat marker |
| wb_cyc | output | 1 | Wishbone cycle |
| wb_stb | output | 1 | Wishbone strobe |
| wb_we | output | 1 | Wishbone write enable |
| wb_adr | output | 30 | Wishbone word address |
| wb_dat_w | output | 32 | Wishbone write data |
| wb_sel | output | 4 | Wishbone byte selects |
| wb_dat_r | input | 32 | Wishbone read data |
| wb_ack | input | 1 | Wishbone acknowledge |

## Verification
A wrong beat counter or a wrong burst register shows up on the Wishbone side at the very next beat. It appears as a wrong `wb_adr`, a Wishbone cycle too many or too few, or an `r_last` on the wrong beat. The bench compares every logged Wishbone cycle of every burst against addresses it computes itself.

A wrong state can also leave the block stuck, or accept a second address while a burst is still open. Either one shows within a few cycles as a missing or doubled B, or a read granted out of turn.

The bench holds ready low for random stretches and stretches ACK randomly, so a lost hold on B, R or the Wishbone cycle becomes visible in the cycle after a stall.

// File: rtl/axwb_pkg.sv
package axwb_pkg;

    typedef enum logic [1:0] {
        BT_FIXED = 2'd0,
        BT_INCR  = 2'd1,
        BT_WRAP  = 2'd2,
        BT_RSVD  = 2'd3
    } burst_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WDATA,
        ST_WBUS,
        ST_WRESP,
        ST_RBUS,
        ST_RDATA
    } state_t;

    localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/axwb_addr_step.sv
module axwb_addr_step
    import axwb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [2:0]        size_i,
    input  logic [LEN_W-1:0]  len_i,
    input  burst_t            kind_i,
    output logic [ADDR_W-1:0] next_o
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] unit_b;
    logic [ADDR_W-1:0] span_m1;
    logic [ADDR_W-1:0] lin_next;

    always_comb begin
        unit_b   = ONE << size_i;
        span_m1  = (((ADDR_W'(len_i)) + ONE) << size_i) - ONE;
        lin_next = addr_i + unit_b;
        unique case (kind_i)
            BT_FIXED: next_o = addr_i;
            BT_WRAP:  next_o = (addr_i & ~span_m1) | (lin_next & span_m1);
            default:  next_o = lin_next;
        endcase
    end

endmodule

// File: rtl/axwb_rr_arb.sv
module axwb_rr_arb (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req_i,
    input  logic       take_i,
    output logic [1:0] gnt_o
);
    // bit 0 = write side, bit 1 = read side
    logic pref_rd;

    always_comb begin
        gnt_o[0] = req_i[0] && (!req_i[1] || !pref_rd);
        gnt_o[1] = req_i[1] && (!req_i[0] ||  pref_rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pref_rd <= 1'b0;
        else if (take_i) pref_rd <= gnt_o[0];
    end

    AST_GNT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o)); // R12
    AST_RR_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && (&req_i) && gnt_o[0]) |=> (!(&req_i) || gnt_o[1])); // R12

endmodule

// File: rtl/axi_wb_bridge.sv
module axi_wb_bridge #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int ID_W   = 8,
    parameter int LEN_W  = 8
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    aw_valid,
    output logic                                    aw_ready,
    input  logic [ADDR_W-1:0]                       aw_addr,
    input  logic [ID_W-1:0]                         aw_id,
    input  logic [LEN_W-1:0]                        aw_len,
    input  logic [2:0]                              aw_size,
    input  logic [1:0]                              aw_burst,
    input  logic                                    w_valid,
    output logic                                    w_ready,
    input  logic [DATA_W-1:0]                       w_data,
    input  logic [DATA_W/8-1:0]                     w_strb,
    input  logic                                    w_last,
    output logic                                    b_valid,
    input  logic                                    b_ready,
    output logic [ID_W-1:0]                         b_id,
    output logic [1:0]                              b_resp,
    input  logic                                    ar_valid,
    output logic                                    ar_ready,
    input  logic [ADDR_W-1:0]                       ar_addr,
    input  logic [ID_W-1:0]                         ar_id,
    input  logic [LEN_W-1:0]                        ar_len,
    input  logic [2:0]                              ar_size,
    input  logic [1:0]                              ar_burst,
    output logic                                    r_valid,
    input  logic                                    r_ready,
    output logic [DATA_W-1:0]                       r_data,
    output logic [ID_W-1:0]                         r_id,
    output logic [1:0]                              r_resp,
    output logic                                    r_last,
    output logic                                    wb_cyc,
    output logic                                    wb_stb,
    output logic                                    wb_we,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0]      wb_adr,
    output logic [DATA_W-1:0]                       wb_dat_w,
    output logic [DATA_W/8-1:0]                     wb_sel,
    input  logic [DATA_W-1:0]                       wb_dat_r,
    input  logic                                    wb_ack
);
    import axwb_pkg::*;

    localparam int SEL_W = DATA_W / 8;
    localparam int OFS_W = $clog2(SEL_W);

    state_t             state, nxt;
    logic [ADDR_W-1:0]  cur_addr, step_addr;
    logic [LEN_W-1:0]   cur_len, beat_cnt;
    logic [2:0]         cur_size;
    burst_t             cur_kind;
    logic [ID_W-1:0]    cur_id;
    logic [DATA_W-1:0]  dbuf;
    logic [SEL_W-1:0]   sbuf;
    logic [1:0]         req, gnt;
    logic               take, beat_last, advance;

    assign req       = {ar_valid, aw_valid};
    assign take      = (state == ST_IDLE) && (|gnt);
    assign beat_last = (beat_cnt == cur_len);
    assign advance   = ((state == ST_WBUS)  && wb_ack  && !beat_last) ||
                       ((state == ST_RDATA) && r_ready && !beat_last);

    axwb_rr_arb u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req),
        .take_i (take),
        .gnt_o  (gnt)
    );

    axwb_addr_step #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_step (
        .addr_i (cur_addr),
        .size_i (cur_size),
        .len_i  (cur_len),
        .kind_i (cur_kind),
        .next_o (step_addr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (gnt[0]) nxt = ST_WDATA;
                      else if (gnt[1]) nxt = ST_RBUS;
            ST_WDATA: if (w_valid) nxt = ST_WBUS;
            ST_WBUS:  if (wb_ack) nxt = beat_last ? ST_WRESP : ST_WDATA;
            ST_WRESP: if (b_ready) nxt = ST_IDLE;
            ST_RBUS:  if (wb_ack) nxt = ST_RDATA;
            ST_RDATA: if (r_ready) nxt = beat_last ? ST_IDLE : ST_RBUS;
            default:  nxt = ST_IDLE;
        endcase
    end

    // burst context and beat data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cur_len  <= '0;
            cur_size <= '0;
            cur_kind <= BT_FIXED;
            cur_id   <= '0;
            beat_cnt <= '0;
            dbuf     <= '0;
            sbuf     <= '0;
        end else begin
            if (take) begin
                cur_addr <= gnt[0] ? aw_addr : ar_addr;
                cur_len  <= gnt[0] ? aw_len  : ar_len;
                cur_size <= gnt[0] ? aw_size : ar_size;
                cur_kind <= burst_t'(gnt[0] ? aw_burst : ar_burst);
                cur_id   <= gnt[0] ? aw_id   : ar_id;
                beat_cnt <= '0;
            end
            if ((state == ST_WDATA) && w_valid) begin
                dbuf <= w_data;
                sbuf <= w_strb;
            end
            if ((state == ST_RBUS) && wb_ack) dbuf <= wb_dat_r;
            if (advance) begin
                cur_addr <= step_addr;
                beat_cnt <= beat_cnt + LEN_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        aw_ready = 1'b0;
        ar_ready = 1'b0;
        w_ready  = 1'b0;
        b_valid  = 1'b0;
        r_valid  = 1'b0;
        r_last   = 1'b0;
        wb_cyc   = 1'b0;
        wb_stb   = 1'b0;
        wb_we    = 1'b0;
        wb_sel   = '1;
        unique case (state)
            ST_IDLE: begin
                aw_ready = gnt[0];
                ar_ready = gnt[1];
            end
            ST_WDATA: w_ready = 1'b1;
            ST_WBUS: begin
                wb_cyc = 1'b1;
                wb_stb = 1'b1;
                wb_we  = 1'b1;
                wb_sel = sbuf;
            end
            ST_WRESP: b_valid = 1'b1;
            ST_RBUS: begin
                wb_cyc = 1'b1;
                wb_stb = 1'b1;
            end
            ST_RDATA: begin
                r_valid = 1'b1;
                r_last  = beat_last;
            end
            default: ;
        endcase
        wb_adr   = cur_addr[ADDR_W-1:OFS_W];
        wb_dat_w = dbuf;
        b_id     = cur_id;
        b_resp   = RESP_OKAY;
        r_data   = dbuf;
        r_id     = cur_id;
        r_resp   = RESP_OKAY;
    end

    AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb && !wb_ack) |=> (wb_cyc && wb_stb && $stable(wb_adr) && $stable(wb_we)
                                 && $stable(wb_dat_w) && $stable(wb_sel))); // R6
    AST_B_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_valid) |-> $past(wb_ack && wb_we)); // R7
    AST_WLAST_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && w_ready) |-> (w_last == beat_last)); // R7
    AST_RLAST_END: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && r_ready && r_last) |=> !r_valid); // R9
    AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && !b_ready) |=> (b_valid && $stable(b_id))); // R10
    AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && !r_ready) |=> (r_valid && $stable(r_data) && $stable(r_id)
                                   && $stable(r_last))); // R10
    AST_NO_SECOND_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc || b_valid || r_valid || w_ready) |-> !(aw_ready || ar_ready)); // R11

endmodule

// File: tb/sim_axi_wb_bridge.sv
`timescale 1ns/1ps
module sim_axi_wb_bridge;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n;
    logic aw_valid, aw_ready; logic [31:0] aw_addr; logic [7:0] aw_id, aw_len;
    logic [2:0] aw_size; logic [1:0] aw_burst;
    logic w_valid, w_ready; logic [31:0] w_data; logic [3:0] w_strb; logic w_last;
    logic b_valid, b_ready; logic [7:0] b_id; logic [1:0] b_resp;
    logic ar_valid, ar_ready; logic [31:0] ar_addr; logic [7:0] ar_id, ar_len;
    logic [2:0] ar_size; logic [1:0] ar_burst;
    logic r_valid, r_ready; logic [31:0] r_data; logic [7:0] r_id; logic [1:0] r_resp; logic r_last;
    logic wb_cyc, wb_stb, wb_we; logic [29:0] wb_adr; logic [31:0] wb_dat_w, wb_dat_r;
    logic [3:0] wb_sel; logic wb_ack;

    axi_wb_bridge u0 (.*);

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Wishbone slave model with random ACK delay and cycle log
    logic [31:0] mem    [256];
    logic [31:0] shadow [256];
    logic [29:0] lg_adr [64];
    logic        lg_we  [64];
    logic [3:0]  lg_sel [64];
    logic [31:0] lg_dat [64];
    int lg_n = 0;
    int dly  = 0;

    initial begin
        for (int i = 0; i < 256; i++) begin mem[i] = 32'h0; shadow[i] = 32'h0; end
        wb_ack = 1'b0; wb_dat_r = 32'h0;
    end

    always @(negedge clk) begin
        if (wb_ack) wb_ack = 1'b0;
        else if (wb_cyc && wb_stb) begin
            if (dly > 0) dly--;
            else begin
                wb_ack = 1'b1;
                if (lg_n < 64) begin
                    lg_adr[lg_n] = wb_adr; lg_we[lg_n] = wb_we;
                    lg_sel[lg_n] = wb_sel; lg_dat[lg_n] = wb_dat_w;
                end
                lg_n++;
                if (wb_we) begin
                    for (int k = 0; k < 4; k++)
                        if (wb_sel[k]) mem[wb_adr[7:0]][8*k +: 8] = wb_dat_w[8*k +: 8];
                end else wb_dat_r = mem[wb_adr[7:0]];
                dly = $urandom_range(0, 2);
            end
        end
    end

    // Independent address model
    function automatic logic [29:0] exp_wadr(logic [31:0] a, logic [7:0] l, logic [2:0] s,
                                             logic [1:0] k, int i);
        logic [63:0] st, span, b;
        st   = 64'd1 << s;
        span = (64'(l) + 64'd1) * st;
        case (k)
            2'd0:    b = 64'(a);
            2'd2:    b = (64'(a) - 64'(a) % span) + ((64'(a) % span + 64'(i) * st) % span);
            default: b = 64'(a) + 64'(i) * st;
        endcase
        return b[31:2];
    endfunction

    function automatic logic [31:0] beat_data(logic [7:0] id, int j, int vi);
        return {id, 8'(j), 8'(vi), 8'hC5};
    endfunction

    // {pad7, strb4, kind2, size3, len8, id8, addr32}
    localparam int NV = 7;
    localparam logic [63:0] VEC [NV] = '{
        {7'd0, 4'hF, 2'd1, 3'd2, 8'd0,  8'h11, 32'h0000_0040},
        {7'd0, 4'hF, 2'd1, 3'd2, 8'd31, 8'h22, 32'h0000_0100},
        {7'd0, 4'h5, 2'd0, 3'd2, 8'd0,  8'h33, 32'h0000_0300},
        {7'd0, 4'hF, 2'd2, 3'd2, 8'd3,  8'h44, 32'h0000_0018},
        {7'd0, 4'hF, 2'd2, 3'd2, 8'd7,  8'hFE, 32'h0000_028C},
        {7'd0, 4'hF, 2'd1, 3'd2, 8'd4,  8'h66, 32'hFFFF_F3F0},
        {7'd0, 4'hF, 2'd0, 3'd2, 8'd3,  8'h5A, 32'h0000_0080}
    };

    task automatic send_aw(input logic [31:0] a, input logic [7:0] l, input logic [2:0] s,
                           input logic [1:0] k, input logic [7:0] i);
        @(negedge clk);
        repeat ($urandom_range(0, 2)) @(negedge clk);
        aw_addr = a; aw_len = l; aw_size = s; aw_burst = k; aw_id = i; aw_valid = 1'b1;
        #1;
        while (!aw_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        aw_valid = 1'b0;
    endtask

    task automatic send_ar(input logic [31:0] a, input logic [7:0] l, input logic [2:0] s,
                           input logic [1:0] k, input logic [7:0] i);
        @(negedge clk);
        repeat ($urandom_range(0, 2)) @(negedge clk);
        ar_addr = a; ar_len = l; ar_size = s; ar_burst = k; ar_id = i; ar_valid = 1'b1;
        #1;
        while (!ar_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        ar_valid = 1'b0;
    endtask

    task automatic send_w(input logic [7:0] l, input logic [7:0] id, input logic [3:0] st, input int vi);
        for (int j = 0; j <= int'(l); j++) begin
            @(negedge clk);
            w_valid = 1'b0;
            repeat ($urandom_range(0, 2)) @(negedge clk);
            w_data = beat_data(id, j, vi); w_strb = st; w_last = (j == int'(l)); w_valid = 1'b1;
            #1;
            while (!w_ready) begin @(negedge clk); #1; end
        end
        @(negedge clk);
        w_valid = 1'b0;
    endtask

    task automatic get_b(input logic [7:0] eid, input int nbeats);
        logic [7:0] id0;
        @(negedge clk); #1;
        while (!b_valid) begin @(negedge clk); #1; end
        chk("R7", "wb beats done before B", 64'(lg_n), 64'(nbeats));
        id0 = b_id;
        repeat ($urandom_range(0, 3)) @(negedge clk);
        #1;
        chk("R10", "b_valid held", 64'(b_valid), 64'd1);
        chk("R10", "b_id held", 64'(b_id), 64'(id0));
        chk("R7", "b_id", 64'(b_id), 64'(eid));
        chk("R7", "b_resp", 64'(b_resp), 64'd0);
        b_ready = 1'b1;
        @(negedge clk);
        b_ready = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk("R7", "no second B", 64'(b_valid), 64'd0);
    endtask

    task automatic get_r(input logic [31:0] a, input logic [7:0] l, input logic [2:0] s,
                         input logic [1:0] k, input logic [7:0] eid);
        logic [31:0] d0;
        for (int j = 0; j <= int'(l); j++) begin
            @(negedge clk); #1;
            while (!r_valid) begin @(negedge clk); #1; end
            d0 = r_data;
            repeat ($urandom_range(0, 3)) @(negedge clk);
            #1;
            chk("R10", "r_valid held", 64'(r_valid), 64'd1);
            chk("R10", "r_data held", 64'(r_data), 64'(d0));
            chk("R8", "r_data", 64'(r_data), 64'(shadow[exp_wadr(a, l, s, k, j) & 30'hFF]));
            chk("R8", "r_id", 64'(r_id), 64'(eid));
            chk("R8", "r_resp", 64'(r_resp), 64'd0);
            chk("R9", "r_last", 64'(r_last), 64'(j == int'(l)));
            r_ready = 1'b1;
            @(negedge clk);
            r_ready = 1'b0;
        end
    endtask

    task automatic check_log(input logic [31:0] a, input logic [7:0] l, input logic [2:0] s,
                             input logic [1:0] k, input bit wr, input logic [3:0] st,
                             input logic [7:0] id, input int vi);
        string rq;
        rq = (k == 2'd0) ? "R4" : (k == 2'd2) ? "R5" : "R3";
        chk(wr ? "R7" : "R9", "wb beat count", 64'(lg_n), 64'(int'(l) + 1));
        for (int j = 0; j <= int'(l) && j < 64; j++) begin
            chk(j == 0 ? "R2" : rq, "wb_adr", 64'(lg_adr[j]), 64'(exp_wadr(a, l, s, k, j)));
            chk(wr ? "R6" : "R8", "wb_we", 64'(lg_we[j]), 64'(wr));
            chk(wr ? "R6" : "R8", "wb_sel", 64'(lg_sel[j]), wr ? 64'(st) : 64'hF);
            if (wr) chk("R6", "wb_dat_w", 64'(lg_dat[j]), 64'(beat_data(id, j, vi)));
        end
    endtask

    task automatic check_idle(input string tag);
        #1;
        chk("R1", {tag, " wb_cyc"}, 64'(wb_cyc), 64'd0);
        chk("R1", {tag, " wb_stb"}, 64'(wb_stb), 64'd0);
        chk("R1", {tag, " b_valid"}, 64'(b_valid), 64'd0);
        chk("R1", {tag, " r_valid"}, 64'(r_valid), 64'd0);
        chk("R1", {tag, " aw_ready"}, 64'(aw_ready), 64'd0);
        chk("R1", {tag, " ar_ready"}, 64'(ar_ready), 64'd0);
    endtask

    task automatic report;
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        rst_n = 1'b0;
        aw_valid = 0; aw_addr = 0; aw_id = 0; aw_len = 0; aw_size = 0; aw_burst = 0;
        w_valid = 0; w_data = 0; w_strb = 0; w_last = 0; b_ready = 0;
        ar_valid = 0; ar_addr = 0; ar_id = 0; ar_len = 0; ar_size = 0; ar_burst = 0;
        r_ready = 0;
        repeat (3) @(negedge clk);
        check_idle("reset");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_idle("after reset");

        // table walk: each vector is written, then read back
        for (int v = 0; v < NV; v++) begin
            logic [31:0] a; logic [7:0] l, id; logic [2:0] s; logic [1:0] k; logic [3:0] st;
            {st, k, s, l, id, a} = VEC[v][56:0];
            lg_n = 0;
            fork
                send_aw(a, l, s, k, id);
                send_w(l, id, st, v);
                get_b(id, int'(l) + 1);
            join
            check_log(a, l, s, k, 1'b1, st, id, v);
            for (int j = 0; j <= int'(l); j++) begin
                logic [7:0] wi;
                wi = 8'(exp_wadr(a, l, s, k, j));
                for (int b = 0; b < 4; b++)
                    if (st[b]) shadow[wi][8*b +: 8] = beat_data(id, j, v) >> (8*b);
            end
            lg_n = 0;
            fork
                send_ar(a, l, s, k, id ^ 8'h80);
                get_r(a, l, s, k, id ^ 8'h80);
            join
            check_log(a, l, s, k, 1'b0, 4'hF, id, v);
        end

        // directed: reset again, then arbitration between concurrent requests
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_idle("mid reset");
        rst_n = 1'b1;
        @(negedge clk);
        aw_addr = 32'h1F0; aw_len = 0; aw_size = 2; aw_burst = 1; aw_id = 8'h71; aw_valid = 1;
        ar_addr = 32'h100; ar_len = 0; ar_size = 2; ar_burst = 1; ar_id = 8'h72; ar_valid = 1;
        #1;
        chk("R12", "write wins first aw_ready", 64'(aw_ready), 64'd1);
        chk("R12", "write wins first ar_ready", 64'(ar_ready), 64'd0);
        @(negedge clk);
        aw_valid = 0;
        #1;
        chk("R11", "ar_ready low during write", 64'(ar_ready), 64'd0);
        w_data = 32'h1357_9BDF; w_strb = 4'hF; w_last = 1; w_valid = 1;
        #1;
        while (!w_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        w_valid = 0;
        #1;
        while (!b_valid) begin
            chk("R11", "ar_ready low before B", 64'(ar_ready), 64'd0);
            @(negedge clk); #1;
        end
        chk("R7", "directed b_id", 64'(b_id), 64'h71);
        b_ready = 1;
        @(negedge clk);
        b_ready = 0;
        aw_addr = 32'h1F4; aw_id = 8'h73; aw_valid = 1;
        #1;
        chk("R12", "read wins next ar_ready", 64'(ar_ready), 64'd1);
        chk("R12", "read wins next aw_ready", 64'(aw_ready), 64'd0);
        @(negedge clk);
        ar_valid = 0;
        #1;
        while (!r_valid) begin @(negedge clk); #1; end
        chk("R8", "directed r_data", 64'(r_data), 64'(shadow[8'h40]));
        chk("R8", "directed r_id", 64'(r_id), 64'h72);
        chk("R9", "directed r_last", 64'(r_last), 64'd1);
        chk("R11", "aw_ready low during read", 64'(aw_ready), 64'd0);
        r_ready = 1;
        @(negedge clk);
        r_ready = 0;
        #1;
        while (!aw_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        aw_valid = 0;
        w_data = 32'h2468_ACE0; w_last = 1; w_valid = 1;
        #1;
        while (!w_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        w_valid = 0;
        #1;
        while (!b_valid) begin @(negedge clk); #1; end
        chk("R7", "second directed b_id", 64'(b_id), 64'h73);
        b_ready = 1;
        @(negedge clk);
        b_ready = 0;
        repeat (3) @(negedge clk);
        check_idle("end");
        report();
    end

endmodule